// File: doc/BRIEF.md
# Floating-Point Status and Exception Accumulator

This block holds the status word of a floating-point unit that sits beside an integer core. Each time a floating-point operation finishes, the datapath presents a completion strobe together with the five exception flags that operation raised, a compare result and, optionally, a non-IEEE trap cause. The block copies the flags into a current-exception field. It then either requests an exception trap, when the operation reported its own trap cause or when any flag it raised is enabled in the trap-enable mask, or it folds the flags into a sticky accrued-exception field. The recorded trap cause stays readable only until the next operation finishes.

Software loads and stores the whole word through a single load strobe and a read bus. Writable fields take the loaded value in one cycle. The trap cause and the pending-queue flag are read-only, and every unused bit reads as zero. The rounding direction and the compare condition code are also driven straight out to the rest of the core.

Top module: `fpu_status_reg`

## Requirements
- R1: After reset every field of the status word is zero, `trap_req` is low, and `round_dir` and `cond_code` are zero.
- R2: With default parameters the word layout is: current exceptions [4:0], accrued exceptions [9:5], condition code [11:10], queue flag [12], trap cause [15:13], trap-enable mask [20:16], rounding precision [22:21] (00 extended, 01 single, 10 double, 11 unused and stored as written) and rounding direction [24:23]. Within each five-bit exception field or mask, the order from high bit to low bit is invalid, overflow, underflow, divide-by-zero, inexact. A load with `ld_en` high and no completion replaces the exception, mask, condition, precision and direction fields on the next clock.
- R3: Bits [31:25] always read zero. A load leaves the trap cause unchanged. Bit 12 always shows the current `queue_nonempty` input.
- R4: On every completion the current-exception field takes `op_exc`.
- R5: When a completion has `op_tt` = 0 and (mask AND `op_exc`) is nonzero, `trap_req` is high on the next cycle, the trap cause becomes 1 (IEEE exception) and the accrued field is unchanged.
- R6: When a completion has `op_tt` = 0 and (mask AND `op_exc`) is zero, the accrued field is ORed with `op_exc`, the trap cause reads 0 and no trap is requested.
- R7: When a completion has `op_tt` nonzero (2 unfinished, 3 unimplemented, 4 sequence error), `trap_req` is high on the next cycle and the trap cause takes `op_tt` whatever the mask holds. The accrued field is unchanged.
- R8: The condition code (0 equal, 1 less, 2 greater, 3 unordered) takes `op_cc` only on a completion with `op_cmp` high that requests no trap. Every other completion leaves it unchanged. `cond_code` mirrors the field.
- R9: `round_dir` mirrors the rounding-direction field (00 nearest, 01 toward zero, 10 toward +infinity, 11 toward -infinity).
- R10: When `ld_en` and `op_done` are high in the same cycle, the completion is applied and the load is dropped.
- R11: `trap_req` is high for exactly the one cycle after each trapping completion, and is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Word to load |
| rd_data | output | 32 | Current status word |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Exception flags of the completing operation |
| op_cmp | input | 1 | Completing operation is a compare |
| op_cc | input | 2 | Compare result |
| op_tt | input | 3 | Non-IEEE trap cause, 0 for none |
| queue_nonempty | input | 1 | Deferred-operation queue holds entries |
| trap_req | output | 1 | Floating-point exception trap request |
| round_dir | output | 2 | Rounding direction to the datapath |
| cond_code | output | 2 | Floating-point condition code to branch logic |

## Verification
A wrong accrued or current field shows on `rd_data` on the very cycle after the completion that corrupted it. The error stays there, because only a load clears sticky bits. A wrong trap decision shows up one cycle after the completion: either `trap_req` fails to pulse or the trap cause field disagrees. A missed hold of the condition code appears on `cond_code` after the first non-compare completion. The bench compares every output against its model on every cycle, so each of these shows within one clock.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int TT_W = 3;

   typedef enum logic [TT_W-1:0] {
      TT_NONE   = 3'd0,
      TT_IEEE   = 3'd1,
      TT_UNFIN  = 3'd2,
      TT_UNIMPL = 3'd3,
      TT_SEQ    = 3'd4
   } trap_cause_e;

   typedef enum logic [1:0] {
      RND_NEAR = 2'd0,
      RND_ZERO = 2'd1,
      RND_PINF = 2'd2,
      RND_NINF = 2'd3
   } round_dir_e;
endpackage

// File: rtl/fsr_exc_unit.sv
module fsr_exc_unit
   import fsr_pkg::*;
#(
   parameter int EXC_W = 5
) (
   input  logic [EXC_W-1:0] tem,
   input  logic [EXC_W-1:0] aexc,
   input  logic [EXC_W-1:0] exc,
   input  logic [TT_W-1:0]  op_tt,
   output logic [EXC_W-1:0] nxt_aexc,
   output logic [TT_W-1:0]  nxt_tt,
   output logic             take_trap
);
   logic [EXC_W-1:0] enabled_hit;
   logic             ieee_trap;
   logic             op_trap;

   genvar gi;
   generate
      for (gi = 0; gi < EXC_W; gi++) begin : g_bit
         assign enabled_hit[gi] = tem[gi] & exc[gi];
         assign nxt_aexc[gi]    = aexc[gi] | (exc[gi] & ~take_trap);
      end
   endgenerate

   assign op_trap   = (op_tt != TT_NONE);
   assign ieee_trap = |enabled_hit;
   assign take_trap = op_trap | ieee_trap;

   always_comb begin
      if (op_trap)        nxt_tt = op_tt;
      else if (ieee_trap) nxt_tt = TT_IEEE;
      else                nxt_tt = TT_NONE;
   end
endmodule

// File: rtl/fsr_word_pack.sv
module fsr_word_pack
   import fsr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int EXC_W   = 5,
   parameter int CC_W    = 2,
   parameter int RND_W   = 2,
   parameter int CEXC_LO = 0,
   parameter int AEXC_LO = 5,
   parameter int CC_LO   = 10,
   parameter int Q_POS   = 12,
   parameter int TT_LO   = 13,
   parameter int TEM_LO  = 16,
   parameter int PREC_LO = 21,
   parameter int RDIR_LO = 23
) (
   input  logic [EXC_W-1:0] cexc,
   input  logic [EXC_W-1:0] aexc,
   input  logic [CC_W-1:0]  cc,
   input  logic             qflag,
   input  logic [TT_W-1:0]  tt,
   input  logic [EXC_W-1:0] tem,
   input  logic [RND_W-1:0] prec,
   input  logic [RND_W-1:0] rdir,
   output logic [DATA_W-1:0] word
);
   always_comb begin
      word = '0;
      word[CEXC_LO +: EXC_W] = cexc;
      word[AEXC_LO +: EXC_W] = aexc;
      word[CC_LO   +: CC_W]  = cc;
      word[Q_POS]            = qflag;
      word[TT_LO   +: TT_W]  = tt;
      word[TEM_LO  +: EXC_W] = tem;
      word[PREC_LO +: RND_W] = prec;
      word[RDIR_LO +: RND_W] = rdir;
   end
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
   import fsr_pkg::*;
#(
   parameter int EXC_W  = 5,
   parameter int CC_W   = 2,
   parameter int RND_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              op_done,
   input  logic [EXC_W-1:0]  op_exc,
   input  logic              op_cmp,
   input  logic [CC_W-1:0]   op_cc,
   input  logic [TT_W-1:0]   op_tt,
   input  logic              queue_nonempty,
   output logic              trap_req,
   output logic [RND_W-1:0]  round_dir,
   output logic [CC_W-1:0]   cond_code
);
   localparam int CEXC_LO = 0;
   localparam int AEXC_LO = CEXC_LO + EXC_W;
   localparam int CC_LO   = AEXC_LO + EXC_W;
   localparam int Q_POS   = CC_LO + CC_W;
   localparam int TT_LO   = Q_POS + 1;
   localparam int TEM_LO  = TT_LO + TT_W;
   localparam int PREC_LO = TEM_LO + EXC_W;
   localparam int RDIR_LO = PREC_LO + RND_W;
   localparam int USED_W  = RDIR_LO + RND_W;

   generate
      if (USED_W > DATA_W) begin : g_bad_width
         $error("fpu_status_reg: fields need %0d bits, DATA_W is %0d", USED_W, DATA_W);
      end
      if (EXC_W < 1 || CC_W < 1 || RND_W < 1) begin : g_bad_field
         $error("fpu_status_reg: field widths must be positive");
      end
   endgenerate

   logic [EXC_W-1:0] cexc_q, aexc_q, tem_q;
   logic [CC_W-1:0]  cc_q;
   logic [TT_W-1:0]  tt_q;
   logic [RND_W-1:0] prec_q, rdir_q;
   logic             trap_q;

   logic [EXC_W-1:0] nxt_aexc;
   logic [TT_W-1:0]  nxt_tt;
   logic             take_trap;
   logic             sw_load;

   assign sw_load = ld_en & ~op_done;

   fsr_exc_unit #(.EXC_W(EXC_W)) i_exc (
      .tem       (tem_q),
      .aexc      (aexc_q),
      .exc       (op_exc),
      .op_tt     (op_tt),
      .nxt_aexc  (nxt_aexc),
      .nxt_tt    (nxt_tt),
      .take_trap (take_trap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cexc_q <= '0;
         aexc_q <= '0;
         tem_q  <= '0;
         cc_q   <= '0;
         tt_q   <= TT_NONE;
         prec_q <= '0;
         rdir_q <= RND_NEAR;
         trap_q <= 1'b0;
      end else begin
         trap_q <= op_done & take_trap;
         if (op_done) begin
            cexc_q <= op_exc;
            aexc_q <= nxt_aexc;
            tt_q   <= nxt_tt;
            if (op_cmp && !take_trap) cc_q <= op_cc;
         end else if (sw_load) begin
            cexc_q <= ld_data[CEXC_LO +: EXC_W];
            aexc_q <= ld_data[AEXC_LO +: EXC_W];
            cc_q   <= ld_data[CC_LO   +: CC_W];
            tem_q  <= ld_data[TEM_LO  +: EXC_W];
            prec_q <= ld_data[PREC_LO +: RND_W];
            rdir_q <= ld_data[RDIR_LO +: RND_W];
         end
      end
   end

   fsr_word_pack #(
      .DATA_W(DATA_W), .EXC_W(EXC_W), .CC_W(CC_W), .RND_W(RND_W),
      .CEXC_LO(CEXC_LO), .AEXC_LO(AEXC_LO), .CC_LO(CC_LO), .Q_POS(Q_POS),
      .TT_LO(TT_LO), .TEM_LO(TEM_LO), .PREC_LO(PREC_LO), .RDIR_LO(RDIR_LO)
   ) i_pack (
      .cexc  (cexc_q),
      .aexc  (aexc_q),
      .cc    (cc_q),
      .qflag (queue_nonempty),
      .tt    (tt_q),
      .tem   (tem_q),
      .prec  (prec_q),
      .rdir  (rdir_q),
      .word  (rd_data)
   );

   assign trap_req  = trap_q;
   assign round_dir = rdir_q;
   assign cond_code = cc_q;

   // R5 R7
   trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && ((op_tt != TT_NONE) || ((tem_q & op_exc) != '0))) |=> trap_req);

   // R6
   aexc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en || op_done) |=> ((aexc_q & $past(aexc_q)) == $past(aexc_q)));

   // R6
   tt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && op_tt == TT_NONE && (tem_q & op_exc) == '0) |=> (tt_q == TT_NONE && !trap_req));

   // R8
   cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(op_done && op_cmp) && !ld_en) |=> $stable(cc_q));

   // R11
   trap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(op_done));
endmodule

// File: tb/test_fpu_status_reg.sv
module test_fpu_status_reg;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [31:0] ld_data = '0;
   logic [31:0] rd_data;
   logic        op_done = 1'b0;
   logic [4:0]  op_exc = '0;
   logic        op_cmp = 1'b0;
   logic [1:0]  op_cc = '0;
   logic [2:0]  op_tt = '0;
   logic        queue_nonempty = 1'b0;
   logic        trap_req;
   logic [1:0]  round_dir;
   logic [1:0]  cond_code;

   int    n_checks = 0;
   int    n_errors = 0;
   int    cycles = 0;
   string tag = "R1";

   // reference state
   logic [4:0] m_cexc, m_aexc, m_tem;
   logic [1:0] m_cc, m_prec, m_rdir;
   logic [2:0] m_tt;
   logic       m_trap;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpu_status_reg i_fpu_status_reg (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data), .rd_data(rd_data),
      .op_done(op_done), .op_exc(op_exc), .op_cmp(op_cmp), .op_cc(op_cc), .op_tt(op_tt),
      .queue_nonempty(queue_nonempty), .trap_req(trap_req), .round_dir(round_dir),
      .cond_code(cond_code)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cexc = 0; m_aexc = 0; m_tem = 0; m_cc = 0; m_prec = 0; m_rdir = 0;
         m_tt = 0; m_trap = 0;
      end else begin
         m_trap = 0;
         if (op_done) begin
            m_cexc = op_exc;
            if (op_tt != 0) begin
               m_trap = 1; m_tt = op_tt;
            end else if ((m_tem & op_exc) != 0) begin
               m_trap = 1; m_tt = 1;
            end else begin
               m_aexc = m_aexc | op_exc; m_tt = 0;
            end
            if (op_cmp && !m_trap) m_cc = op_cc;
         end else if (ld_en) begin
            m_cexc = ld_data[4:0];
            m_aexc = ld_data[9:5];
            m_cc   = ld_data[11:10];
            m_tem  = ld_data[20:16];
            m_prec = ld_data[22:21];
            m_rdir = ld_data[24:23];
         end
      end
   end

   function automatic logic [31:0] exp_word();
      logic [31:0] w = '0;
      w[4:0] = m_cexc; w[9:5] = m_aexc; w[11:10] = m_cc; w[12] = queue_nonempty;
      w[15:13] = m_tt; w[20:16] = m_tem; w[22:21] = m_prec; w[24:23] = m_rdir;
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(tag, rd_data, exp_word());
         check("R11", {31'b0, trap_req}, {31'b0, m_trap});
         check("R9", {30'b0, round_dir}, {30'b0, m_rdir});
         check("R8", {30'b0, cond_code}, {30'b0, m_cc});
      end
   end

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #1;
         op_done = 0; ld_en = 0;
      end
   endtask

   task automatic do_load(input logic [31:0] w);
      @(negedge clk); #1;
      op_done = 0; ld_en = 1; ld_data = w;
      @(negedge clk); #1;
      ld_en = 0;
   endtask

   task automatic do_op(input logic [4:0] e, input logic cmp, input logic [1:0] c,
                        input logic [2:0] t);
      @(negedge clk); #1;
      ld_en = 0; op_done = 1; op_exc = e; op_cmp = cmp; op_cc = c; op_tt = t;
      @(negedge clk); #1;
      op_done = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      tag = "R1";
      check("R1", rd_data, 32'h0);
      check("R1", {31'b0, trap_req}, 32'h0);

      // R2 load of every writable field, reserved bits set high (R3)
      tag = "R2";
      do_load(32'hFFFF_FFFF);
      idle(1);
      check("R2", rd_data, 32'h01FF_0FFF);
      tag = "R3";
      queue_nonempty = 1;
      idle(1);
      check("R3", rd_data[31:25], 32'h0);
      check("R3", {31'b0, rd_data[12]}, 32'h1);
      queue_nonempty = 0;

      // R9 all rounding directions, precision field 11 stored
      tag = "R9";
      for (int r = 0; r < 4; r++) begin
         do_load({7'b0, r[1:0], 2'b11, 21'b0});
         idle(1);
         check("R9", {30'b0, round_dir}, r);
      end

      // clear, enable only invalid (bit 4) and div-by-zero (bit 1)
      do_load({11'b0, 5'b10010, 16'b0});

      // R4 R6 untrapped accrual
      tag = "R6";
      do_op(5'b00001, 0, 0, 0);
      do_op(5'b01000, 0, 0, 0);
      idle(1);
      check("R6", {27'b0, rd_data[9:5]}, 32'b01001);
      check("R4", {27'b0, rd_data[4:0]}, 32'b01000);

      // R5 enabled exception traps, accrued untouched
      tag = "R5";
      do_op(5'b00010, 0, 0, 0);
      check("R5", {31'b0, trap_req}, 32'h1);
      idle(1);
      check("R5", {29'b0, rd_data[15:13]}, 32'd1);
      check("R5", {27'b0, rd_data[9:5]}, 32'b01001);
      check("R11", {31'b0, trap_req}, 32'h0);

      // R6 trap cause clears on next clean completion
      tag = "R6";
      do_op(5'b00100, 0, 0, 0);
      idle(1);
      check("R6", {29'b0, rd_data[15:13]}, 32'd0);

      // R7 op-supplied causes take precedence
      tag = "R7";
      for (int t = 2; t <= 4; t++) begin
         do_op(5'b10000, 0, 0, t[2:0]);
         idle(1);
         check("R7", {29'b0, rd_data[15:13]}, t);
      end
      do_op(5'b00001, 0, 0, 3'd2);
      idle(1);
      check("R7", {27'b0, rd_data[9:5]}, 32'b01101);

      // R3 load does not touch trap cause
      tag = "R3";
      do_load({11'b0, 5'b10010, 16'b0});
      idle(1);

      // R8 compares set the code, others hold it, trapping compare holds
      tag = "R8";
      for (int c = 0; c < 4; c++) begin
         do_op(5'b00000, 1, c[1:0], 0);
         idle(1);
         check("R8", {30'b0, cond_code}, c);
      end
      do_op(5'b00000, 0, 2'd1, 0);
      do_op(5'b10000, 1, 2'd0, 0);
      idle(1);
      check("R8", {30'b0, cond_code}, 32'd3);

      // R10 simultaneous load and completion: completion wins
      tag = "R10";
      @(negedge clk); #1;
      ld_en = 1; ld_data = 32'h0000_03FF; op_done = 1; op_exc = 5'b00001;
      op_cmp = 0; op_tt = 0;
      @(negedge clk); #1;
      ld_en = 0; op_done = 0;
      idle(1);
      check("R10", {27'b0, rd_data[4:0]}, 32'b00001);

      // R11 back-to-back trapping completions
      tag = "R11";
      do_op(5'b10000, 0, 0, 0);
      do_op(5'b00000, 0, 0, 3'd3);
      idle(3);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule